// File: doc/BRIEF.md
# Small Multi-Cycle 8-bit Processor Core

This block is a compact processor that runs a packed 8-bit instruction set out of a single byte-wide memory that holds both code and data. It has four general registers (x, y, i, j), a carry flag, a zero flag and an 8-bit program counter. A separate port interface serves input and output. Every instruction is one opcode byte, optionally followed by one constant byte k. Execution is multi-cycle: fetch the opcode, optionally fetch the constant, then execute. The add/subtract, increment/decrement and shift datapath lives in its own unit.

The opcode byte is laid out so that decode stays shallow. Bit 4 separates register operands from indirect ones. Bits 3-2 always name the destination (or, for stores and port writes, the register being sent out). Bits 1-0 name the source, addressing mode or sub-operation. The memory has a registered read: an address driven in one cycle returns its byte in the next. A port read returns its data combinationally in the same cycle as the read strobe.

Top module: `tcpu_core`

## Requirements
- R1: While reset is held, and until the first fetch, the core drives address 0 with no write, port-read or port-write strobe. Reset clears the program counter, both flags and all registers. The first fetch comes from address 0.
- R2: Each instruction takes 3 cycles: fetch, opcode, execute. Instructions that carry a constant byte k take one extra cycle. All external strobes occur only in the execute cycle. Register indices are x=00, y=01, i=10, j=11.
- R3: Opcode 0000 dd ss copies register ss into dd. Opcode 0001 dd mm loads dd from an indirect operand. The operand is mm=00 memory at i, mm=01 memory at j, mm=10 the constant k, or mm=11 memory at address k. Moves and loads leave the flags unchanged.
- R4: Opcode 0011 rr mm writes register rr to memory. The address is i for mm=00 and j for mm=01; for mm=10 and mm=11 it is the constant k.
- R5: Opcode 1 s c m dd ss performs arithmetic on dd. Bit 6 (s) selects subtract, bit 5 (c) uses the carry, and bit 4 (m) selects the indirect operand of R3 instead of register ss. The result is dd+b+cin, or dd+~b+cin when subtracting. Here cin is the carry flag when c=1, and otherwise 0 for add and 1 for subtract. The carry flag takes bit 8 of the sum, and the zero flag is set when the result is zero.
- R6: Opcode 0100 dd 00 increments dd and 0100 dd 01 decrements dd, wrapping modulo 256. Both update the zero flag and leave carry unchanged.
- R7: Opcode 0010 dd ss shifts dd right by one. The vacated top bit is filled with the old bit 7 for ss=00, with 0 for ss=01, with the old bit 0 for ss=10, and with the old carry for ss=11. Carry takes the old bit 0, and the zero flag follows the result.
- R8: Opcode 0100 dd 10 k loads dd from port k, with a one-cycle read strobe. Opcode 0100 dd 11 k sends dd to port k, with a one-cycle write strobe.
- R9: Opcode 0111 00 cc k loads the program counter with k when its condition holds, and otherwise continues after k. The conditions are cc=00 always, 01 carry set, 10 carry clear, and 11 zero set.
- R10: The unassigned opcodes 0101 xxxx, 0110 xxxx and 0111 ee xx with ee≠00 each take one byte and 3 cycles. They change no register, no flag and no memory.
- R11: At most one of the memory write, port read and port write strobes is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| mem_addr | output | 8 | Memory address for fetch, load and store |
| mem_wdata | output | 8 | Store data |
| mem_rdata | input | 8 | Read data, valid one cycle after its address |
| mem_we | output | 1 | Memory write strobe |
| io_addr | output | 8 | Port number |
| io_wdata | output | 8 | Port output data |
| io_rdata | input | 8 | Port input data, sampled during the read strobe |
| io_rd | output | 1 | Port read strobe |
| io_wr | output | 1 | Port write strobe |

## Verification
The first fetch begins two cycles after reset release. From there, every visible result can be dated exactly: a store or port strobe falls in the last cycle of its instruction, which is 3 cycles long, or 4 when a constant byte follows the opcode. The scoreboard entries therefore carry the cycle in which each strobe must appear, counted from reset release. The total comes from summing the lengths of every instruction on the taken path, including the skipped-over no-ops and jumps. The monitor samples on the falling edge and compares the kind, address, data and cycle of each strobe, so a wrong branch or a miscounted instruction length shows up as a timing mismatch even when the data are right.

// File: rtl/tcpu_pkg.sv
package tcpu_pkg;

  localparam int OPW  = 8;
  localparam int RSW  = 2;
  localparam int NREG = 1 << RSW;

  typedef enum logic [1:0] {
    ST_FETCH,
    ST_OPC,
    ST_KBYTE,
    ST_EXEC
  } state_t;

  typedef enum logic [3:0] {
    K_NOP,
    K_MOV,
    K_LDR,
    K_STR,
    K_SHF,
    K_INC,
    K_DEC,
    K_IN,
    K_OUT,
    K_JMP,
    K_ARI
  } kind_t;

  localparam logic [1:0] SH_ASR = 2'b00;
  localparam logic [1:0] SH_LSR = 2'b01;
  localparam logic [1:0] SH_ROR = 2'b10;
  localparam logic [1:0] SH_RRC = 2'b11;

  localparam logic [1:0] MODE_KIMM = 2'b10;

  typedef struct packed {
    kind_t          kind;
    logic [RSW-1:0] dst;
    logic [1:0]     sel;
    logic           ind;
    logic           sub;
    logic           usec;
    logic           need_k;
    logic           mem_rd;
  } dec_t;

endpackage

// File: rtl/tcpu_decode.sv
module tcpu_decode
  import tcpu_pkg::*;
(
  input  logic [OPW-1:0] opc,
  output dec_t           d
);

  always_comb begin
    d        = '0;
    d.kind   = K_NOP;
    d.dst    = opc[3:2];
    d.sel    = opc[1:0];
    d.ind    = opc[4];
    d.sub    = opc[6];
    d.usec   = opc[5];
    if (opc[7]) begin
      d.kind   = K_ARI;
      d.need_k = opc[4] & opc[1];
      d.mem_rd = opc[4] & (opc[1:0] != MODE_KIMM);
    end else begin
      case (opc[6:4])
        3'b000: d.kind = K_MOV;
        3'b001: begin
          d.kind   = K_LDR;
          d.need_k = opc[1];
          d.mem_rd = (opc[1:0] != MODE_KIMM);
        end
        3'b010: d.kind = K_SHF;
        3'b011: begin
          d.kind   = K_STR;
          d.need_k = opc[1];
        end
        3'b100: begin
          case (opc[1:0])
            2'b00:   d.kind = K_INC;
            2'b01:   d.kind = K_DEC;
            2'b10:   begin d.kind = K_IN;  d.need_k = 1'b1; end
            default: begin d.kind = K_OUT; d.need_k = 1'b1; end
          endcase
        end
        3'b111: begin
          if (opc[3:2] == 2'b00) begin
            d.kind   = K_JMP;
            d.need_k = 1'b1;
          end
        end
        default: d.kind = K_NOP;
      endcase
    end
  end

endmodule

// File: rtl/tcpu_regfile.sv
module tcpu_regfile
  import tcpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic           clk,
  input  logic           rst_ni,
  input  logic           we,
  input  logic [RSW-1:0] waddr,
  input  logic [DW-1:0]  wdata,
  input  logic [RSW-1:0] raddr_a,
  input  logic [RSW-1:0] raddr_b,
  input  logic [RSW-1:0] raddr_c,
  output logic [DW-1:0]  rdata_a,
  output logic [DW-1:0]  rdata_b,
  output logic [DW-1:0]  rdata_c
);

  logic [NREG-1:0][DW-1:0] q;

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic          en;
    logic [DW-1:0] r_q;
    assign en = we && (waddr == RSW'(g));
    always_ff @(posedge clk or negedge rst_ni) begin
      if (!rst_ni)  r_q <= '0;
      else if (en)  r_q <= wdata;
    end
    assign q[g] = r_q;
  end

  assign rdata_a = q[raddr_a];
  assign rdata_b = q[raddr_b];
  assign rdata_c = q[raddr_c];

endmodule

// File: rtl/tcpu_alu.sv
module tcpu_alu
  import tcpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  kind_t         kind,
  input  logic          sub,
  input  logic          usec,
  input  logic [1:0]    sel,
  input  logic [DW-1:0] a,
  input  logic [DW-1:0] b,
  input  logic          cin,
  output logic [DW-1:0] res,
  output logic          cout,
  output logic          zero
);

  logic [DW:0]   sum;
  logic [DW-1:0] bop;
  logic          ci;

  always_comb begin
    bop  = sub ? ~b : b;
    ci   = usec ? cin : sub;
    sum  = {1'b0, a} + {1'b0, bop} + (DW+1)'(ci);
    res  = a;
    cout = cin;
    case (kind)
      K_ARI: begin
        res  = sum[DW-1:0];
        cout = sum[DW];
      end
      K_INC: res = a + DW'(1);
      K_DEC: res = a - DW'(1);
      K_SHF: begin
        cout = a[0];
        case (sel)
          SH_ASR:  res = {a[DW-1], a[DW-1:1]};
          SH_LSR:  res = {1'b0,    a[DW-1:1]};
          SH_ROR:  res = {a[0],    a[DW-1:1]};
          default: res = {cin,     a[DW-1:1]};
        endcase
      end
      default: res = a;
    endcase
    zero = (res == '0);
  end

endmodule

// File: rtl/tcpu_core.sv
module tcpu_core
  import tcpu_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  output logic [DW-1:0] mem_addr,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  output logic          mem_we,
  output logic [DW-1:0] io_addr,
  output logic [DW-1:0] io_wdata,
  input  logic [DW-1:0] io_rdata,
  output logic          io_rd,
  output logic          io_wr
);

  // reset: asynchronous assert, two-stage synchronous release
  logic [1:0] rs_q;
  logic       rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_q = rs_q[1];

  state_t         st_q, st_d;
  logic [DW-1:0]  pc_q, pc_d;
  logic [OPW-1:0] ir_q, ir_d;
  logic [DW-1:0]  k_q, k_d;
  logic           c_q, c_d;
  logic           z_q, z_d;

  logic [OPW-1:0] cur_op;
  dec_t           dec;
  kind_t          cur_kind;

  assign cur_op   = (st_q == ST_OPC) ? mem_rdata[OPW-1:0] : ir_q;
  assign cur_kind = dec.kind;

  tcpu_decode u_dec (
    .opc (cur_op),
    .d   (dec)
  );

  logic           rf_we;
  logic [DW-1:0]  rf_wd;
  logic [DW-1:0]  rd_a, rd_b, rd_c;
  logic [RSW-1:0] ptr_sel;

  // pointer registers i and j are indices 2 and 3
  assign ptr_sel = {1'b1, dec.sel[0]};

  tcpu_regfile #(.DW(DW)) u_rf (
    .clk     (clk),
    .rst_ni  (rst_q),
    .we      (rf_we),
    .waddr   (dec.dst),
    .wdata   (rf_wd),
    .raddr_a (dec.dst),
    .raddr_b (dec.sel),
    .raddr_c (ptr_sel),
    .rdata_a (rd_a),
    .rdata_b (rd_b),
    .rdata_c (rd_c)
  );

  logic [DW-1:0] opnd;
  logic [DW-1:0] alu_res;
  logic          alu_c, alu_z;

  always_comb begin
    opnd = rd_b;
    if ((cur_kind == K_LDR || cur_kind == K_ARI) && dec.ind)
      opnd = (dec.sel == MODE_KIMM) ? k_q : mem_rdata;
  end

  tcpu_alu #(.DW(DW)) u_alu (
    .kind (cur_kind),
    .sub  (dec.sub),
    .usec (dec.usec),
    .sel  (dec.sel),
    .a    (rd_a),
    .b    (opnd),
    .cin  (c_q),
    .res  (alu_res),
    .cout (alu_c),
    .zero (alu_z)
  );

  logic in_exec;
  logic cond_ok;
  assign in_exec = (st_q == ST_EXEC);

  always_comb begin
    case (dec.sel)
      2'b00:   cond_ok = 1'b1;
      2'b01:   cond_ok = c_q;
      2'b10:   cond_ok = !c_q;
      default: cond_ok = z_q;
    endcase
  end

  // next-state process
  always_comb begin
    st_d  = st_q;
    pc_d  = pc_q;
    ir_d  = ir_q;
    k_d   = k_q;
    c_d   = c_q;
    z_d   = z_q;
    rf_we = 1'b0;
    rf_wd = alu_res;
    case (st_q)
      ST_FETCH: begin
        pc_d = pc_q + DW'(1);
        st_d = ST_OPC;
      end
      ST_OPC: begin
        ir_d = cur_op;
        if (dec.need_k) begin
          pc_d = pc_q + DW'(1);
          st_d = ST_KBYTE;
        end else begin
          st_d = ST_EXEC;
        end
      end
      ST_KBYTE: begin
        k_d  = mem_rdata;
        st_d = ST_EXEC;
      end
      default: begin
        st_d = ST_FETCH;
        case (cur_kind)
          K_MOV, K_LDR: begin
            rf_we = 1'b1;
            rf_wd = opnd;
          end
          K_IN: begin
            rf_we = 1'b1;
            rf_wd = io_rdata;
          end
          K_INC, K_DEC: begin
            rf_we = 1'b1;
            z_d   = alu_z;
          end
          K_ARI, K_SHF: begin
            rf_we = 1'b1;
            c_d   = alu_c;
            z_d   = alu_z;
          end
          K_JMP: begin
            if (cond_ok) pc_d = k_q;
          end
          default: ;
        endcase
      end
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      st_q <= ST_FETCH;
      pc_q <= '0;
      ir_q <= '0;
      k_q  <= '0;
      c_q  <= 1'b0;
      z_q  <= 1'b0;
    end else begin
      st_q <= st_d;
      pc_q <= pc_d;
      ir_q <= ir_d;
      k_q  <= k_d;
      c_q  <= c_d;
      z_q  <= z_d;
    end
  end

  // memory address selection
  always_comb begin
    mem_addr = pc_q;
    case (st_q)
      ST_OPC:   if (!dec.need_k && dec.mem_rd) mem_addr = rd_c;
      ST_KBYTE: if (dec.mem_rd)                mem_addr = mem_rdata;
      ST_EXEC:  if (cur_kind == K_STR)         mem_addr = dec.sel[1] ? k_q : rd_c;
      default:  mem_addr = pc_q;
    endcase
  end

  assign mem_we    = in_exec && (cur_kind == K_STR);
  assign mem_wdata = rd_a;
  assign io_addr   = k_q;
  assign io_wdata  = rd_a;
  assign io_rd     = in_exec && (cur_kind == K_IN);
  assign io_wr     = in_exec && (cur_kind == K_OUT);

endmodule

// File: rtl/tcpu_core_chk.sv
module tcpu_core_chk
  import tcpu_pkg::*;
#(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_q,
  input state_t        st,
  input logic [DW-1:0] pc,
  input logic          carry,
  input logic          zero,
  input kind_t         kind,
  input logic          mem_we,
  input logic          io_rd,
  input logic          io_wr
);

  p_one_strobe_r11: assert property (@(posedge clk) disable iff (!rst_q)
    $onehot0({mem_we, io_rd, io_wr}));

  p_strobe_in_exec_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (mem_we || io_rd || io_wr) |-> (st == ST_EXEC));

  p_exec_to_fetch_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_EXEC) |=> (st == ST_FETCH));

  p_fetch_step_r2: assert property (@(posedge clk) disable iff (!rst_q)
    (st == ST_FETCH) |=> (pc == DW'($past(pc) + 1'b1)));

  p_incdec_carry_r6: assert property (@(posedge clk) disable iff (!rst_q)
    ((st == ST_EXEC) && (kind == K_INC || kind == K_DEC)) |=> (carry == $past(carry)));

  p_nop_flags_r10: assert property (@(posedge clk) disable iff (!rst_q)
    ((st == ST_EXEC) && (kind == K_NOP)) |=> ($stable(carry) && $stable(zero)));

endmodule

bind tcpu_core tcpu_core_chk #(.DW(DW)) u_chk (
  .clk    (clk),
  .rst_q  (rst_q),
  .st     (st_q),
  .pc     (pc_q),
  .carry  (c_q),
  .zero   (z_q),
  .kind   (cur_kind),
  .mem_we (mem_we),
  .io_rd  (io_rd),
  .io_wr  (io_wr)
);

// File: tb/tcpu_core_test.sv
module tcpu_core_test;

  localparam int EV_MEM = 0;
  localparam int EV_OUT = 1;
  localparam int EV_IN  = 2;

  typedef struct {
    int       kind;
    logic [7:0] addr;
    logic [7:0] data;
    int       cyc;
    string    tag;
  } ev_t;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] mem_addr, mem_wdata, mem_rdata;
  logic       mem_we;
  logic [7:0] io_addr, io_wdata, io_rdata;
  logic       io_rd, io_wr;

  int   errors = 0;
  int   checks = 0;
  int   cyc = 0;
  bit   done = 1'b0;
  ev_t  sb[$];
  logic [7:0] mem [256];

  always #5 clk = ~clk;

  tcpu_core uut (
    .clk       (clk),
    .rst_n     (rst_n),
    .mem_addr  (mem_addr),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .mem_we    (mem_we),
    .io_addr   (io_addr),
    .io_wdata  (io_wdata),
    .io_rdata  (io_rdata),
    .io_rd     (io_rd),
    .io_wr     (io_wr)
  );

  // memory model: registered read, one cycle latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr] <= mem_wdata;
    mem_rdata <= mem[mem_addr];
  end

  assign io_rdata = io_addr ^ 8'hC3;

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s", msg);
    end
  endtask

  // driver side of the scoreboard
  task automatic expect_ev(input int kind, input logic [7:0] addr,
                           input logic [7:0] data, input int c, input string tag);
    ev_t e;
    e.kind = kind; e.addr = addr; e.data = data; e.cyc = c; e.tag = tag;
    sb.push_back(e);
  endtask

  task automatic got_ev(input int kind, input logic [7:0] addr, input logic [7:0] data);
    ev_t e;
    if (sb.size() == 0) begin
      check(1'b0, $sformatf("R2 unexpected event kind=%0d addr=%h data=%h cyc=%0d expected none",
                            kind, addr, data, cyc));
    end else begin
      e = sb.pop_front();
      check(kind == e.kind && addr == e.addr && cyc == e.cyc &&
            (kind == EV_IN || data == e.data),
            $sformatf("%s actual kind=%0d addr=%h data=%h cyc=%0d expected kind=%0d addr=%h data=%h cyc=%0d",
                      e.tag, kind, addr, data, cyc, e.kind, e.addr, e.data, e.cyc));
    end
  endtask

  // monitor
  always @(negedge clk) begin
    if (rst_n && !done) begin
      if (mem_we || io_wr || io_rd)
        check($countones({mem_we, io_wr, io_rd}) == 1,
              $sformatf("R11 strobes actual=%b expected one-hot", {mem_we, io_wr, io_rd}));
      if (mem_we) got_ev(EV_MEM, mem_addr, mem_wdata);
      if (io_wr)  got_ev(EV_OUT, io_addr, io_wdata);
      if (io_rd)  got_ev(EV_IN,  io_addr, 8'h00);
    end
  end

  task automatic put(input logic [7:0] a, input logic [7:0] v);
    mem[a] = v;
  endtask

  task automatic load_program();
    for (int n = 0; n < 256; n++) mem[n] = 8'h00;
    put(8'h00, 8'h12); put(8'h01, 8'h35);   // LDR x,#35
    put(8'h02, 8'h16); put(8'h03, 8'h0F);   // LDR y,#0F
    put(8'h04, 8'h81);                      // ADD x,y
    put(8'h05, 8'h43); put(8'h06, 8'h10);   // OUT (10),x
    put(8'h07, 8'hD2); put(8'h08, 8'h44);   // SUB x,#44
    put(8'h09, 8'h73); put(8'h0A, 8'h20);   // JMP Z,20
    put(8'h20, 8'h43); put(8'h21, 8'h11);   // OUT (11),x
    put(8'h22, 8'h71); put(8'h23, 8'h30);   // JMP C,30
    put(8'h30, 8'h41);                      // DEC x
    put(8'h31, 8'h72); put(8'h32, 8'h40);   // JMP NC,40 (not taken)
    put(8'h33, 8'h73); put(8'h34, 8'h40);   // JMP Z,40 (not taken)
    put(8'h35, 8'hB2); put(8'h36, 8'h00);   // ADC x,#00
    put(8'h37, 8'h43); put(8'h38, 8'h12);   // OUT (12),x
    put(8'h39, 8'h40);                      // INC x
    put(8'h3A, 8'h71); put(8'h3B, 8'h50);   // JMP C,50
    put(8'h50, 8'h1A); put(8'h51, 8'h80);   // LDR i,#80
    put(8'h52, 8'h30);                      // STR (i),x
    put(8'h53, 8'h1F); put(8'h54, 8'h90);   // LDR j,(90)
    put(8'h55, 8'h3F); put(8'h56, 8'hC0);   // STR (C0),j
    put(8'h57, 8'h14);                      // LDR y,(i)
    put(8'h58, 8'hF7); put(8'h59, 8'h90);   // SBC y,(90)
    put(8'h5A, 8'h47); put(8'h5B, 8'h13);   // OUT (13),y
    put(8'h5C, 8'h72); put(8'h5D, 8'h60);   // JMP NC,60
    put(8'h60, 8'h4E); put(8'h61, 8'h2B);   // IN j,(2B)
    put(8'h62, 8'h2C);                      // ASR j
    put(8'h63, 8'h4F); put(8'h64, 8'h14);   // OUT (14),j
    put(8'h65, 8'h2F);                      // RRC j
    put(8'h66, 8'h03);                      // MOV x,j
    put(8'h67, 8'h21);                      // LSR x
    put(8'h68, 8'h22);                      // ROR x
    put(8'h69, 8'h23);                      // RRC x
    put(8'h6A, 8'h43); put(8'h6B, 8'h15);   // OUT (15),x
    put(8'h6C, 8'h55);                      // unassigned
    put(8'h6D, 8'h7C);                      // unassigned
    put(8'h6E, 8'h43); put(8'h6F, 8'h16);   // OUT (16),x
    put(8'h70, 8'h72); put(8'h71, 8'h78);   // JMP NC,78
    put(8'h78, 8'hC5);                      // SUB y,y
    put(8'h79, 8'h47); put(8'h7A, 8'h17);   // OUT (17),y
    put(8'h7B, 8'h70); put(8'h7C, 8'h7B);   // JMP 7B (park)
    put(8'h90, 8'hA7);                      // data
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    load_program();
    expect_ev(EV_OUT, 8'h10, 8'h44,  16, "R5 ADD reg, R3 LDR imm, R2");
    expect_ev(EV_OUT, 8'h11, 8'h00,  28, "R5 SUB imm, R9 JMP Z taken, R2");
    expect_ev(EV_OUT, 8'h12, 8'h00,  51, "R5 ADC, R6 DEC, R9 not taken, R2");
    expect_ev(EV_MEM, 8'h80, 8'h01,  65, "R4 STR (i), R6 INC keeps carry, R2");
    expect_ev(EV_MEM, 8'hC0, 8'hA7,  73, "R4 STR (k), R3 LDR (k), R2");
    expect_ev(EV_OUT, 8'h13, 8'h5A,  84, "R5 SBC (k), R3 LDR (i), R2");
    expect_ev(EV_IN,  8'h2B, 8'h00,  92, "R8 IN strobe, R9 JMP NC taken, R2");
    expect_ev(EV_OUT, 8'h14, 8'hF4,  99, "R7 ASR, R8 IN data, R2");
    expect_ev(EV_OUT, 8'h15, 8'hCF, 118, "R7 RRC LSR ROR, R3 MOV, R2");
    expect_ev(EV_OUT, 8'h16, 8'hCF, 128, "R10 unassigned opcodes one byte no effect, R2");
    expect_ev(EV_OUT, 8'h17, 8'h00, 139, "R5 SUB reg zero, R10 carry kept, R9, R2");

    rst_n = 1'b0;
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(mem_addr == 8'h00, $sformatf("R1 reset address actual=%h expected=00", mem_addr));
    check(!mem_we && !io_wr && !io_rd,
          $sformatf("R1 reset strobes actual=%b expected=000", {mem_we, io_wr, io_rd}));
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_addr == 8'h00 && !mem_we,
          $sformatf("R1 pre-fetch address actual=%h expected=00", mem_addr));
    while (cyc < 180) @(negedge clk);
    check(sb.size() == 0, $sformatf("R2 events left actual=%0d expected=0", sb.size()));
    check(mem[8'h80] == 8'h01, $sformatf("R4 mem[80] actual=%h expected=01", mem[8'h80]));
    check(mem[8'hC0] == 8'hA7, $sformatf("R4 mem[C0] actual=%h expected=A7", mem[8'hC0]));
    finish_run();
  end

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog R2 actual=timeout expected=completion");
      finish_run();
    end
  end

endmodule